// File: doc/BRIEF.md
# Dual-Converter Serial Result Framer

This block is the digital output side of a two-channel, simultaneous-sampling 12-bit converter. It takes one parallel result from each of the two converters and shifts them out on two serial data pins. An active-low chip select frames each transfer, and a host-driven serial clock paces it. Both pins and the chip select are sampled in the block's own system clock domain. Edges are found by comparing each pin with its value one system clock earlier. The serial clock must therefore run several times slower than the system clock.

When chip select falls, the block latches two selects: the channel-pair select, which it drives on to the converters, and the range select. The range select sets both the analog range, also driven out, and the starting output coding (straight binary or twos complement). A change of the range select seen at the eighth serial clock fall flips the coding alone. If chip select is held low for 32 serial clocks, each pin first sends its own converter's word and then the other converter's word. A single pin can therefore collect both results. Results arrive on a valid/ready port. The port accepts a pair only while chip select is high and no frame is open (`res_ready` high). While a frame is open, `res_ready` is low, `res_valid` is ignored and the held pair cannot change. An accepted pair is used by every later frame until another pair is accepted.

Top module: `dual_result_framer`

## Requirements
- R1: Each 16-bit word on a pin is, in send order: a 0 bit, then a status bit holding the converter identity (0 = converter A, 1 = converter B), then a status bit holding the latched channel select, then a status bit holding the coding in force (1 = twos complement), then the 12 result bits, MSB first.
- R2: The first bit (index 0) is driven in the system clock cycle that detects the chip-select fall. Bit index k (k ≥ 1) is driven in the cycle that detects the k-th serial clock fall of the frame. The data outputs change at no other time while a frame is open.
- R3: `dout_a` sends converter A's word and `dout_b` sends converter B's word, in the same bit slots.
- R4: Bit indices 16 to 31 send the other converter's word: converter B on `dout_a` and converter A on `dout_b`. After index 31, both pins hold 0.
- R5: At the chip-select fall, `chan_sel` is latched into `conv_chan` and into the channel status bit. `conv_chan` holds this value until the next chip-select fall.
- R6: At the chip-select fall, `range_sel` is latched into `conv_range`. A low level selects straight binary coding. A high level selects twos complement, which sends the result with its MSB inverted.
- R7: If `range_sel` at the eighth serial clock fall differs from its latched value, the coding flips. The flip applies to every coding status bit and every data MSB driven after that fall (that is, the second word), and `conv_range` does not change.
- R8: While chip select is high, `dout_oe` is low and both data outputs are 0.
- R9: Chip select rising mid-frame aborts the frame. The next frame starts again from bit index 0.
- R10: `res_ready` is high exactly while `cs_n` is high and no frame is open. A pair offered while `res_ready` is low is ignored. An accepted pair is sent by all later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Host serial clock, sampled in the clk domain |
| cs_n | input | 1 | Active-low chip select, sampled in the clk domain |
| chan_sel | input | 1 | Channel-pair select, latched at the chip-select fall |
| range_sel | input | 1 | Range and coding select |
| res_valid | input | 1 | Result pair offered |
| res_ready | output | 1 | Result pair can be accepted |
| res_a | input | 12 | Converter A result, straight binary |
| res_b | input | 12 | Converter B result, straight binary |
| dout_a | output | 1 | Serial data pin A |
| dout_b | output | 1 | Serial data pin B |
| dout_oe | output | 1 | Data pin drive enable (low = high impedance) |
| conv_chan | output | 1 | Channel select for the converters |
| conv_range | output | 1 | Analog range select for the converters |

## Verification
The hardest case to reach is a coding flip at the eighth serial clock fall that must show up only in the second chained word, while the first word's status bit and MSB keep the original coding. The bench sweeps every combination of channel, starting range and range toggle over a set of result patterns, including all-zero, all-one and both sides of mid-scale. In each frame it changes `range_sel` just after the chip-select fall and clocks all 32 bits plus one trailing bit, so the toggle is in place at the eighth fall. Aborted frames, and result offers made during an open frame, are inserted between sweep frames.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int unsigned STATUS_W = 3;

  // Coding applied to a straight-binary result.
  typedef enum logic {
    CODE_BINARY = 1'b0,
    CODE_TWOS   = 1'b1
  } coding_e;
endpackage

// File: rtl/pin_edge_tracker.sv
module pin_edge_tracker #(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fell,
  output logic rose
);
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= IDLE_LEVEL;
    else        pin_q <= pin;
  end

  assign fell = pin_q & ~pin;
  assign rose = ~pin_q & pin;
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer #(
  parameter int unsigned WORD_BITS   = 16,
  parameter int unsigned SWITCH_EDGE = 8,
  localparam int unsigned FRAME_BITS = 2 * WORD_BITS,
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             cs_fell,
  input  logic             sclk_fell,
  input  logic             chan_sel,
  input  logic             range_sel,
  output logic             active,
  output logic             load,
  output logic [IDX_W-1:0] load_idx,
  output logic             load_chan,
  output logic             load_coding,
  output logic             conv_chan,
  output logic             conv_range
);
  import framer_pkg::*;

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_nxt;
  coding_e          coding_q;
  logic             flip_now;

  assign idx_nxt  = (idx_q == IDX_W'(FRAME_BITS)) ? idx_q : idx_q + 1'b1;
  assign flip_now = active && sclk_fell &&
                    (idx_nxt == IDX_W'(SWITCH_EDGE)) && (range_sel != conv_range);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      idx_q      <= '0;
      coding_q   <= CODE_BINARY;
      conv_chan  <= 1'b0;
      conv_range <= 1'b0;
    end else if (cs_fell) begin
      active     <= 1'b1;
      idx_q      <= '0;
      conv_chan  <= chan_sel;
      conv_range <= range_sel;
      coding_q   <= coding_e'(range_sel);
    end else if (cs_n) begin
      active <= 1'b0;
      idx_q  <= '0;
    end else if (active && sclk_fell) begin
      idx_q <= idx_nxt;
      if (flip_now) coding_q <= coding_e'(~coding_q);
    end
  end

  // Bit driven in this cycle: index 0 at the select fall, else the next index.
  assign load        = cs_fell || (active && sclk_fell && !cs_n);
  assign load_idx    = cs_fell ? '0 : idx_nxt;
  assign load_chan   = cs_fell ? chan_sel : conv_chan;
  assign load_coding = cs_fell ? range_sel : logic'(coding_q);
endmodule

// File: rtl/frame_lane.sv
module frame_lane #(
  parameter int unsigned DATA_W = 12,
  parameter logic        OWN_ID = 1'b0,
  localparam int unsigned WORD_BITS  = 1 + framer_pkg::STATUS_W + DATA_W,
  localparam int unsigned FRAME_BITS = 2 * WORD_BITS,
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic              load_chan,
  input  logic              load_coding,
  input  logic [DATA_W-1:0] own_res,
  input  logic [DATA_W-1:0] other_res,
  output logic              dout
);
  logic              second;
  logic [IDX_W-1:0]  pos;
  logic [DATA_W-1:0] word_res;
  logic [DATA_W-1:0] coded;
  logic              bit_val;

  always_comb begin
    second   = (load_idx >= IDX_W'(WORD_BITS));
    pos      = second ? load_idx - IDX_W'(WORD_BITS) : load_idx;
    word_res = second ? other_res : own_res;
    coded    = word_res ^ {load_coding, {(DATA_W-1){1'b0}}};
    bit_val  = 1'b0;
    if (load_idx >= IDX_W'(FRAME_BITS)) bit_val = 1'b0;
    else if (pos == IDX_W'(1))          bit_val = OWN_ID ^ second;
    else if (pos == IDX_W'(2))          bit_val = load_chan;
    else if (pos == IDX_W'(3))          bit_val = load_coding;
    else if (pos >= IDX_W'(4))          bit_val = coded[IDX_W'(WORD_BITS - 1) - pos];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= 1'b0;
    else if (load) dout <= bit_val;
    else if (clear) dout <= 1'b0;
  end
endmodule

// File: rtl/dual_result_framer.sv
module dual_result_framer #(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned SWITCH_EDGE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              chan_sel,
  input  logic              range_sel,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_a,
  input  logic [DATA_W-1:0] res_b,
  output logic              dout_a,
  output logic              dout_b,
  output logic              dout_oe,
  output logic              conv_chan,
  output logic              conv_range
);
  localparam int unsigned WORD_BITS  = 1 + framer_pkg::STATUS_W + DATA_W;
  localparam int unsigned FRAME_BITS = 2 * WORD_BITS;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS + 1);
  localparam int unsigned LANES      = 2;

  logic             sclk_fell, sclk_rose, cs_fell, cs_rose;
  logic             active, load, load_chan, load_coding;
  logic [IDX_W-1:0] load_idx;
  logic [DATA_W-1:0] hold [LANES];
  logic [LANES-1:0] lane_out;

  pin_edge_tracker #(.IDLE_LEVEL(1'b1)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .pin(sclk), .fell(sclk_fell), .rose(sclk_rose)
  );
  pin_edge_tracker #(.IDLE_LEVEL(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .pin(cs_n), .fell(cs_fell), .rose(cs_rose)
  );

  frame_sequencer #(.WORD_BITS(WORD_BITS), .SWITCH_EDGE(SWITCH_EDGE)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_fell(cs_fell), .sclk_fell(sclk_fell),
    .chan_sel(chan_sel), .range_sel(range_sel), .active(active), .load(load),
    .load_idx(load_idx), .load_chan(load_chan), .load_coding(load_coding),
    .conv_chan(conv_chan), .conv_range(conv_range)
  );

  // Result intake: open only between frames.
  assign res_ready = cs_n & ~active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold[0] <= '0;
      hold[1] <= '0;
    end else if (res_valid && res_ready) begin
      hold[0] <= res_a;
      hold[1] <= res_b;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    frame_lane #(.DATA_W(DATA_W), .OWN_ID(g[0])) u_lane (
      .clk(clk), .rst_n(rst_n), .clear(~active | cs_rose), .load(load),
      .load_idx(load_idx), .load_chan(load_chan), .load_coding(load_coding),
      .own_res(hold[g]), .other_res(hold[LANES-1-g]), .dout(lane_out[g])
    );
  end

  assign dout_a  = lane_out[0];
  assign dout_b  = lane_out[1];
  assign dout_oe = active;

  logic unused_edges;
  assign unused_edges = sclk_rose;
endmodule

// File: rtl/dual_result_framer_chk.sv
module dual_result_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic cs_n,
  input logic res_valid,
  input logic res_ready,
  input logic dout_a,
  input logic dout_b,
  input logic dout_oe,
  input logic conv_chan,
  input logic conv_range
);
  // R8
  oe_off_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !dout_oe);

  // R8
  quiet_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> (!dout_a && !dout_b));

  // R1
  leading_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> (!dout_a && !dout_b));

  // R2
  change_on_fall_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && $past(dout_oe) && !$stable(dout_a)) |-> ($past(sclk, 2) && !$past(sclk)));

  // R2
  change_on_fall_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && $past(dout_oe) && !$stable(dout_b)) |-> ($past(sclk, 2) && !$past(sclk)));

  // R5
  chan_held_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && $past(dout_oe)) |-> $stable(conv_chan));

  // R7
  range_held_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && $past(dout_oe)) |-> $stable(conv_range));

  // R10
  no_intake_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe || !cs_n) |-> !res_ready);

  logic unused_valid;
  assign unused_valid = res_valid;
endmodule

bind dual_result_framer dual_result_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .res_valid(res_valid),
  .res_ready(res_ready), .dout_a(dout_a), .dout_b(dout_b), .dout_oe(dout_oe),
  .conv_chan(conv_chan), .conv_range(conv_range)
);

// File: tb/test_dual_result_framer.sv
module test_dual_result_framer;
  localparam int PERIOD = 10;
  localparam int DW     = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, cs_n = 1'b1, chan_sel = 1'b0, range_sel = 1'b0, res_valid = 1'b0;
  logic [DW-1:0] res_a = '0, res_b = '0;
  logic res_ready, dout_a, dout_b, dout_oe, conv_chan, conv_range;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  dual_result_framer i_dual_result_framer (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .chan_sel(chan_sel),
    .range_sel(range_sel), .res_valid(res_valid), .res_ready(res_ready),
    .res_a(res_a), .res_b(res_b), .dout_a(dout_a), .dout_b(dout_b),
    .dout_oe(dout_oe), .conv_chan(conv_chan), .conv_range(conv_range)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected bit from the word layout of R1, R3, R4, R6, R7.
  function automatic logic exp_bit(input int idx, input logic [DW-1:0] own, input logic [DW-1:0] oth,
                                   input logic id, input logic ch, input logic c0, input logic c1);
    int p;
    logic [DW-1:0] v;
    logic cd;
    if (idx >= 32) return 1'b0;
    p  = idx % 16;
    v  = (idx >= 16) ? oth : own;
    cd = (idx >= 16) ? c1 : c0;
    if (p == 0) return 1'b0;
    if (p == 1) return id ^ (idx >= 16);
    if (p == 2) return ch;
    if (p == 3) return cd;
    if (p == 4) return v[DW-1] ^ cd;
    return v[DW-1-(p-4)];
  endfunction

  task automatic offer(input logic [DW-1:0] a, input logic [DW-1:0] b);
    res_a = a; res_b = b; res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  // One frame of nfall serial clock falls; range_sel toggled after the select fall when sw.
  task automatic frame(input int nfall, input logic ch, input logic rg, input logic sw,
                       input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic c1;
    c1 = rg ^ sw;
    chan_sel = ch; range_sel = rg;
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    check("R8 oe on", dout_oe, 1);
    check("R5 conv_chan", conv_chan, ch);
    check("R6 conv_range", conv_range, rg);
    check("R10 ready low in frame", res_ready, 0);
    check("R2 first bit a", dout_a, exp_bit(0, a, b, 0, ch, rg, c1));
    check("R2 first bit b", dout_b, exp_bit(0, b, a, 1, ch, rg, c1));
    range_sel = rg ^ sw;
    chan_sel = ~ch;
    for (int k = 1; k <= nfall; k++) begin
      sclk = 1'b0;
      @(negedge clk);
      check(k >= 16 ? "R4 chained a" : "R1 R3 bit a", dout_a, exp_bit(k, a, b, 0, ch, rg, c1));
      check(k >= 16 ? "R4 chained b" : "R1 R3 bit b", dout_b, exp_bit(k, b, a, 1, ch, rg, c1));
      sclk = 1'b1;
      @(negedge clk);
      check("R2 hold on rise a", dout_a, exp_bit(k, a, b, 0, ch, rg, c1));
      @(negedge clk);
    end
    check("R7 range unchanged", conv_range, rg);
    cs_n = 1'b1;
    @(negedge clk);
    check("R8 oe off", dout_oe, 0);
    check("R8 pins quiet", {dout_a, dout_b}, 0);
    check("R10 ready high", res_ready, 1);
  endtask

  initial begin
    automatic logic [DW-1:0] pats [6] = '{12'h000, 12'hFFF, 12'h800, 12'h7FF, 12'hA5C, 12'h136};
    repeat (3) @(negedge clk);
    check("R8 reset oe", dout_oe, 0);
    check("R8 reset pins", {dout_a, dout_b}, 0);
    check("R10 reset ready", res_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int pi = 0; pi < 6; pi++) begin
      automatic logic [DW-1:0] a = pats[pi];
      automatic logic [DW-1:0] b = ~pats[(pi + 2) % 6] ^ 12'h0F0;
      offer(a, b);
      for (int m = 0; m < 8; m++)
        frame(33, m[0], m[1], m[2], a, b);
    end
    // R9: aborted frame, then a full frame restarts at index 0.
    offer(12'h5A3, 12'h3C9);
    frame(10, 1, 0, 0, 12'h5A3, 12'h3C9);
    frame(20, 0, 1, 1, 12'h5A3, 12'h3C9);
    frame(32, 1, 1, 0, 12'h5A3, 12'h3C9);
    // R10: offer during an open frame is ignored.
    chan_sel = 1'b0; range_sel = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    res_a = 12'hFFF; res_b = 12'h001; res_valid = 1'b1;
    @(negedge clk);
    check("R10 ready low while offered", res_ready, 0);
    res_valid = 1'b0;
    cs_n = 1'b1;
    @(negedge clk);
    frame(32, 0, 0, 0, 12'h5A3, 12'h3C9);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule